// File: doc/BRIEF.md
# Serial SAR Converter Frame Controller

This block is a synchronous master for a serial successive-approximation converter with a three-wire link: an active-low conversion-start line, a serial clock and one serial data line. Each accepted request opens one frame. The block pulls the conversion-start line low and runs the serial clock at the system clock divided by `SCLK_DIV`. It then collects one result, MSB first, from the data line and presents it on a parallel bus with a one-cycle valid pulse.

Each request carries a mode bit. In a normal frame the block releases the start line late in the frame, which keeps the converter in continuous operation. In a power-down frame it releases the line early, after eight serial clock rising edges, which places the converter in partial power-down, and it reports no result. Every frame begins with a short preamble of zero bits, and the block checks it. The first normal conversion after reset only warms up the converter and is never reported. Requests use a valid/ready handshake: a request is held until it sees `req_ready` high on a rising clock edge. The result bus has no back-pressure, so a consumer must take each result in the cycle its valid pulse is high.

Top module: `sar_readout_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `conv_n` is 1, `sclk` is 0, `busy` is 0, `smp_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted only on a rising edge where `req_valid` and `req_ready` are both 1. In the next cycle `busy` is 1, `conv_n` is 0 and `req_ready` is 0. `req_ready` is never 1 while `busy` is 1.
- R3: During a frame, `sclk` rises once every `SCLK_DIV` system clocks. Outside a frame, `sclk` is 0.
- R4: A normal frame (`req_pd`=0) gives exactly 16 `sclk` rising edges (3 preamble + 12 data + 1). `conv_n` returns to 1 together with the 15th rising edge, which lies inside the window from the 14th to the 16th edge.
- R5: A power-down frame (`req_pd`=1) gives exactly 8 `sclk` rising edges. `conv_n` returns to 1 together with the 8th edge, and the frame produces no `smp_valid` pulse.
- R6: The bit on `sdata` is launched by one `sclk` rising edge and sampled on the next. The bits sampled on edges 5 through 16 form `smp_data[11]` down to `smp_data[0]`.
- R7: The first normal frame after reset produces no `smp_valid` pulse. A power-down frame does not count as that first conversion.
- R8: The preamble bits are sampled on edges 2, 3 and 4. If any of them is 1, `smp_err` is 1 together with that frame's result. Otherwise `smp_err` is 0.
- R9: Between two frames, `conv_n` stays high for at least `GAP_CLKS` system clocks.
- R10: `smp_valid` is high for exactly one cycle per reported result. It is not held back by the consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Controller can accept a request |
| req_pd | input | 1 | Mode of the requested frame: 1 = partial power-down, 0 = normal |
| busy | output | 1 | A frame is in progress |
| conv_n | output | 1 | Active-low conversion-start line to the converter |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |
| smp_valid | output | 1 | One-cycle strobe for a new result |
| smp_data | output | RES_BITS | Result, MSB first from the frame |
| smp_err | output | 1 | Preamble of this result contained a 1 |

## Verification
A behavioural converter model serves back-to-back frames with results at the extremes (all zeros, all ones, lone MSB, lone LSB) and with alternating patterns. Together these separate bit-order and off-by-one-edge errors from stuck bits. Power-down frames are placed first after reset and also between normal frames. This shows that they yield no result, stop after eight edges and do not replace the warm-up conversion. Preamble corruption in each of the three positions tests that the error flag covers every preamble edge and only those edges.

// File: rtl/sar_ctrl_pkg.sv
`timescale 1ns/1ps
package sar_ctrl_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_RUN  = 2'd1,
    FS_TAIL = 2'd2
  } frame_state_t;
endpackage

// File: rtl/sar_sclk_gen.sv
`timescale 1ns/1ps
module sar_sclk_gen #(
  parameter int SCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int CW   = $clog2(SCLK_DIV);
  localparam int HALF = SCLK_DIV / 2;

  logic [CW-1:0] cnt;

  // rise/fall mark the system edge on which sclk changes
  assign rise = run && (cnt == CW'(SCLK_DIV - 1));
  assign fall = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= rise ? '0 : cnt + CW'(1);
      if (rise)      sclk <= 1'b1;
      else if (fall) sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_frame_seq.sv
`timescale 1ns/1ps
module sar_frame_seq
  import sar_ctrl_pkg::*;
#(
  parameter int PRE_BITS = 3,
  parameter int RES_BITS = 12,
  parameter int PD_EDGE  = 8,
  parameter int GAP_CLKS = 6,
  localparam int LAST_EDGE = PRE_BITS + RES_BITS + 1,
  localparam int EW        = $clog2(LAST_EDGE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_pd,
  output logic          req_ready,
  output logic          busy,
  output logic          conv_n,
  output logic          run,
  input  logic          rise,
  input  logic          fall,
  output logic          samp,
  output logic [EW-1:0] edge_no,
  output logic          last_hit,
  output logic          discard
);
  localparam int REL_EDGE = LAST_EDGE - 1;
  localparam int GW       = $clog2(GAP_CLKS + 1);

  frame_state_t  state;
  logic          pd_q;
  logic          warm_done;
  logic [EW-1:0] edge_q;
  logic [GW-1:0] gap_q;

  assign busy      = (state != FS_IDLE);
  assign run       = busy;
  assign req_ready = (state == FS_IDLE) && (gap_q == '0);
  assign samp      = (state == FS_RUN) && rise;
  assign edge_no   = edge_q + EW'(1);
  assign last_hit  = samp && !pd_q && (edge_no == EW'(LAST_EDGE));
  assign discard   = !warm_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FS_IDLE;
      conv_n    <= 1'b1;
      pd_q      <= 1'b0;
      warm_done <= 1'b0;
      edge_q    <= '0;
      gap_q     <= '0;
    end else begin
      if (gap_q != '0) gap_q <= gap_q - GW'(1);
      case (state)
        FS_IDLE: begin
          if (req_valid && req_ready) begin
            state  <= FS_RUN;
            conv_n <= 1'b0;
            pd_q   <= req_pd;
            edge_q <= '0;
          end
        end
        FS_RUN: begin
          if (samp) begin
            edge_q <= edge_no;
            if (pd_q && edge_no == EW'(PD_EDGE)) begin
              conv_n <= 1'b1;
              gap_q  <= GW'(GAP_CLKS);
              state  <= FS_TAIL;
            end
            if (!pd_q && edge_no == EW'(REL_EDGE)) begin
              conv_n <= 1'b1;
              gap_q  <= GW'(GAP_CLKS);
            end
            if (last_hit) begin
              state     <= FS_TAIL;
              warm_done <= 1'b1;
            end
          end
        end
        FS_TAIL: begin
          if (fall) state <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_shift_capture.sv
`timescale 1ns/1ps
module sar_shift_capture #(
  parameter int PRE_BITS = 3,
  parameter int RES_BITS = 12,
  localparam int LAST_EDGE = PRE_BITS + RES_BITS + 1,
  localparam int EW        = $clog2(LAST_EDGE + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                samp,
  input  logic [EW-1:0]       edge_no,
  input  logic                sdata,
  input  logic                last_hit,
  input  logic                discard,
  output logic [RES_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                err_o
);
  localparam int FIRST_DATA = PRE_BITS + 2;

  logic [RES_BITS-1:0] shreg;
  logic                err_q;
  logic                pre_hit;

  assign pre_hit = samp && (edge_no >= EW'(2)) && (edge_no <= EW'(PRE_BITS + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      err_q   <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= last_hit && !discard;
      if (start)                err_q <= 1'b0;
      else if (pre_hit && sdata) err_q <= 1'b1;
      if (samp && edge_no >= EW'(FIRST_DATA))
        shreg <= {shreg[RES_BITS-2:0], sdata};
      if (last_hit) begin
        data_o <= {shreg[RES_BITS-2:0], sdata};
        err_o  <= err_q;
      end
    end
  end
endmodule

// File: rtl/sar_readout_ctrl.sv
`timescale 1ns/1ps
module sar_readout_ctrl #(
  parameter int SCLK_DIV = 4,
  parameter int RES_BITS = 12,
  parameter int PRE_BITS = 3,
  parameter int PD_EDGE  = 8,
  parameter int GAP_CLKS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_pd,
  output logic                busy,
  output logic                conv_n,
  output logic                sclk,
  input  logic                sdata,
  output logic                smp_valid,
  output logic [RES_BITS-1:0] smp_data,
  output logic                smp_err
);
  localparam int LAST_EDGE = PRE_BITS + RES_BITS + 1;
  localparam int EW        = $clog2(LAST_EDGE + 1);

  logic          run, rise, fall, samp, last_hit, discard;
  logic [EW-1:0] edge_no;

  sar_sclk_gen #(.SCLK_DIV(SCLK_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(sclk), .rise(rise), .fall(fall)
  );

  sar_frame_seq #(
    .PRE_BITS(PRE_BITS), .RES_BITS(RES_BITS),
    .PD_EDGE(PD_EDGE), .GAP_CLKS(GAP_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pd(req_pd),
    .req_ready(req_ready), .busy(busy), .conv_n(conv_n), .run(run),
    .rise(rise), .fall(fall), .samp(samp), .edge_no(edge_no),
    .last_hit(last_hit), .discard(discard)
  );

  sar_shift_capture #(.PRE_BITS(PRE_BITS), .RES_BITS(RES_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .start(req_valid && req_ready),
    .samp(samp), .edge_no(edge_no), .sdata(sdata), .last_hit(last_hit),
    .discard(discard), .data_o(smp_data), .valid_o(smp_valid), .err_o(smp_err)
  );
endmodule

// File: rtl/sar_readout_ctrl_chk.sv
`timescale 1ns/1ps
module sar_readout_ctrl_chk #(
  parameter int GAP_CLKS = 6
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic conv_n,
  input logic sclk,
  input logic smp_valid
);
  logic [15:0] hi_cnt;
  logic        fell_once;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      fell_once <= 1'b0;
    end else begin
      if (conv_n) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
      else        hi_cnt <= '0;
      if (!conv_n) fell_once <= 1'b1;
    end
  end

  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !conv_n);

  a_r3_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r4_start_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_n |-> busy);

  a_r9_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n) && fell_once |-> hi_cnt >= 16'(GAP_CLKS));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
endmodule

bind sar_readout_ctrl sar_readout_ctrl_chk #(.GAP_CLKS(GAP_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .conv_n(conv_n), .sclk(sclk), .smp_valid(smp_valid)
);

// File: tb/sar_readout_ctrl_bench.sv
`timescale 1ns/1ps
module sar_readout_ctrl_bench;
  localparam int DIV = 4, GAP = 6, CLK_NS = 20;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, req_pd = 1'b0, sdata = 1'b0;
  logic req_ready, busy, conv_n, sclk, smp_valid, smp_err;
  logic [11:0] smp_data;

  sar_readout_ctrl #(.SCLK_DIV(DIV), .GAP_CLKS(GAP)) u_sar_readout_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pd(req_pd), .busy(busy), .conv_n(conv_n), .sclk(sclk), .sdata(sdata),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_err(smp_err)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [15:0] model_q[$];
  logic [12:0] exp_q[$];
  bit seen_normal = 0;

  // behavioural converter
  logic [14:0] word = '0;
  bit cur_pd = 0;
  int k = 0, frames = 0;
  time t_edge = 0, t_rel = 0;

  always @(negedge conv_n) begin
    if (frames > 0) begin
      if (cur_pd) check(k == 8, "R5", "edges in frame", k, 8);
      else        check(k == 16, "R4", "edges in frame", k, 16);
      check(($time - t_rel) >= GAP*CLK_NS, "R9", "start line high time",
            int'(($time - t_rel)/CLK_NS), GAP);
    end
    frames++;
    k = 0;
    if (model_q.size() == 0) check(0, "R2", "frame without request", 0, 1);
    else {cur_pd, word} = model_q.pop_front();
    #1 sdata = 1'b0;
  end

  always @(posedge sclk) begin
    if (k >= 1) check(($time - t_edge) == DIV*CLK_NS, "R3", "sclk period",
                      int'($time - t_edge), DIV*CLK_NS);
    t_edge = $time;
    k++;
    #1 sdata = (k <= 15) ? word[15-k] : 1'b0;
  end

  always @(posedge conv_n) begin
    #2;
    t_rel = $time - 2;
    if (frames > 0) begin
      if (cur_pd) check(k == 8, "R5", "release edge", k, 8);
      else        check(k == 15, "R4", "release edge", k, 15);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      if (exp_q.size() == 0) check(0, "R5/R7", "unexpected result", int'(smp_data), 0);
      else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        check(smp_data == e[11:0], "R6", "result data", int'(smp_data), int'(e[11:0]));
        check(smp_err == e[12], "R8", "preamble flag", int'(smp_err), int'(e[12]));
      end
      @(negedge clk);
      check(!smp_valid, "R10", "valid width", int'(smp_valid), 0);
    end
  end

  task automatic issue(bit pd, logic [11:0] d, logic [2:0] pre);
    model_q.push_back({pd, pre, d});
    if (!pd) begin
      if (seen_normal) exp_q.push_back({|pre, d});
      seen_normal = 1;
    end
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1;
    req_pd    = pd;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !conv_n && !req_ready, "R2", "accept response",
          int'({busy, conv_n, req_ready}), 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(conv_n == 1'b1, "R1", "conv_n in reset", int'(conv_n), 1);
    check(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !smp_valid && req_ready, "R1", "after reset",
          int'({busy, smp_valid, req_ready}), 3'b001);
    issue(1, 12'hFFF, 3'b000);   // power-down first: not the warm-up (R7)
    issue(0, 12'h123, 3'b000);   // warm-up, discarded (R7)
    issue(0, 12'hABC, 3'b000);
    issue(0, 12'h000, 3'b000);
    issue(0, 12'hFFF, 3'b000);
    issue(0, 12'h800, 3'b000);
    issue(0, 12'h001, 3'b000);
    issue(0, 12'h5A5, 3'b010);   // R8 middle preamble bit
    issue(0, 12'h6C3, 3'b100);   // R8 first preamble bit
    issue(1, 12'hFFF, 3'b000);   // R5 power-down between frames
    issue(0, 12'h3C3, 3'b000);
    issue(0, 12'h0F0, 3'b001);   // R8 last preamble bit
    do @(negedge clk); while (busy);
    repeat (10) @(negedge clk);
    check(k == 16, "R4", "edges in last frame", k, 16);
    check(exp_q.size() == 0, "R6", "results outstanding", exp_q.size(), 0);
    check(!sclk && conv_n, "R3", "idle lines", int'({sclk, conv_n}), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule